// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the execution stage of a small accumulator-oriented 8-bit controller. Each cycle it can carry out one operation between the working accumulator W and a second operand. The second operand is either a file-register value or an 8-bit constant taken from the instruction. The block produces the result byte and tells the surrounding datapath where to store it: back into the accumulator, or back into the file register that supplied the operand. The block keeps the carry (C), digit carry (DC) and zero (Z) status bits in its own register. Each operation updates only the bits defined for it.

The caller presents an operation code, a literal-select bit, a destination bit and the three data values, and raises `exec_en` for one cycle. Fetch, opcode decoding, register-file storage and any skip or branch control are outside the block. The result and the two write enables depend only on the current inputs and are valid in the same cycle. The status bits are registered and show the new values after the next rising clock edge. The rotate operations read the carry bit as it stands before that edge.

Top module: `accalu_core`

## Requirements
- R1: For a register-form operation (`lit_sel`=0) with `exec_en`=1 and a defined code, `dest_f`=1 raises `f_we` only, and `dest_f`=0 raises `w_we` only.
- R2: With `lit_sel`=1 the second operand is `k_in` instead of `f_in`, and the result always goes to W (`w_we`=1, `f_we`=0) whatever `dest_f` is.
- R3: Code 0 (add) gives operand + W modulo 256. It sets C to the carry out of bit 7, DC to the carry out of bit 3 into bit 4, and Z when the result is zero.
- R4: Code 1 (subtract) gives operand − W, computed as operand + ~W + 1. C=1 means no borrow out of bit 7 and DC=1 means no borrow out of the low nibble. Z is set when the result is zero.
- R5: Codes 2, 3 and 4 (and, inclusive or, exclusive or of operand and W) update Z only. C and DC keep their values.
- R6: Code 5 (move operand) returns the operand unchanged and updates Z only. With `dest_f`=1 it writes f back to itself, so the only visible effect is Z.
- R7: Code 6 (move W) returns W, writes it to f when `dest_f`=1, and changes no status bit.
- R8: Code 7 (complement) returns the bitwise inverse of the operand and updates Z only.
- R9: Codes 8 (increment) and 9 (decrement) return operand ± 1 modulo 256 and update Z only. C and DC keep their values.
- R10: Code 10 rotates the operand left through C: the old C enters bit 0 and bit 7 leaves into C. Code 11 rotates right through C: the old C enters bit 7 and bit 0 leaves into C. DC and Z keep their values.
- R11: Code 12 (clear) returns zero and sets Z. C and DC keep their values.
- R12: When `exec_en`=0, or for codes 13 to 15, both write enables are low and all three status bits hold.
- R13: While `rst_n` is low at a rising edge, C, DC and Z are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_en | input | 1 | Perform the presented operation this cycle |
| op_code | input | 4 | Operation code (0..12 defined) |
| lit_sel | input | 1 | 1: use `k_in` as operand, result to W |
| dest_f | input | 1 | Destination for register forms: 0 W, 1 f |
| w_in | input | 8 | Accumulator value |
| f_in | input | 8 | File register operand |
| k_in | input | 8 | Literal operand |
| result | output | 8 | Result byte (combinational) |
| w_we | output | 1 | Store result into W |
| f_we | output | 1 | Store result into f |
| c_flag | output | 1 | Carry / not-borrow status bit |
| dc_flag | output | 1 | Digit carry status bit |
| z_flag | output | 1 | Zero status bit |

## Verification
`result`, `w_we` and `f_we` depend only on the current inputs, so they are due in the cycle the operation is presented. The bench drives each operation just after a falling edge and samples these outputs a nanosecond later, before the next rising edge. The status bits change on the rising edge that consumes `exec_en`. The bench therefore drops `exec_en` just after that edge and reads C, DC and Z then, so that a second operation cannot overwrite the value being checked. The rotate vectors are ordered so that the carry entering each rotate is the carry left by the vector before it.

// File: rtl/accalu_pkg.sv
`timescale 1ns/1ps
// Package: shared operation codes and status-bit types for the accumulator ALU.
// Assumes a 4-bit operation code; codes above OP_CLR are reserved.
package accalu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_IOR  = 4'd3,
        OP_XOR  = 4'd4,
        OP_MOVF = 4'd5,
        OP_MOVW = 4'd6,
        OP_COMF = 4'd7,
        OP_INCF = 4'd8,
        OP_DECF = 4'd9,
        OP_RLF  = 4'd10,
        OP_RRF  = 4'd11,
        OP_CLR  = 4'd12
    } alu_op_e;

    localparam int FLAG_CNT = 3;

    // Status bits, packed so that bit 2 is C, bit 1 is DC and bit 0 is Z.
    typedef struct packed {
        logic c;
        logic dc;
        logic z;
    } flags_t;

endpackage

// File: rtl/accalu_decode.sv
`timescale 1ns/1ps
// Module: accalu_decode
// Turns the operation code, literal select and destination bit into the
// write enables, the status-bit update mask and the datapath selects.
// Assumes that codes above OP_CLR are reserved and must have no effect.
module accalu_decode
    import accalu_pkg::*;
(
    input  logic         exec_en,
    input  logic [3:0]   op_code,
    input  logic         lit_sel,
    input  logic         dest_f,
    output logic         w_we,
    output logic         f_we,
    output flags_t       upd_mask,
    output logic         use_arith,
    output logic         arith_sub
);

    logic op_known;

    // Classify the code and pick which status bits it updates.
    always_comb begin
        op_known  = 1'b1;
        use_arith = 1'b0;
        arith_sub = 1'b0;
        upd_mask  = '0;
        case (op_code)
            OP_ADD: begin
                use_arith = 1'b1;
                upd_mask  = '{c: 1'b1, dc: 1'b1, z: 1'b1};
            end
            OP_SUB: begin
                use_arith = 1'b1;
                arith_sub = 1'b1;
                upd_mask  = '{c: 1'b1, dc: 1'b1, z: 1'b1};
            end
            OP_AND, OP_IOR, OP_XOR, OP_MOVF,
            OP_COMF, OP_INCF, OP_DECF, OP_CLR: upd_mask.z = 1'b1;
            OP_RLF, OP_RRF:                    upd_mask.c = 1'b1;
            OP_MOVW:                           upd_mask   = '0;
            default:                           op_known   = 1'b0;
        endcase
    end

    // Route the result: literal forms always go to W, others follow dest_f.
    always_comb begin
        w_we = exec_en && op_known && (lit_sel || !dest_f);
        f_we = exec_en && op_known && !lit_sel && dest_f;
    end

endmodule

// File: rtl/accalu_addsub.sv
`timescale 1ns/1ps
// Module: accalu_addsub
// Adds W to the operand, or subtracts W from it by adding the two's
// complement. Returns the carry out of the top bit and out of the low half.
// Assumes DATA_W is even so that the half-carry boundary is well defined.
module accalu_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] opnd,
    input  logic [DATA_W-1:0] acc,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              half_carry
);

    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] acc_x;
    logic [DATA_W:0]   full_sum;
    logic [HALF:0]     low_sum;

    // Invert W for subtraction; the +1 enters as the carry-in.
    always_comb begin
        acc_x      = sub ? ~acc : acc;
        full_sum   = {1'b0, opnd} + {1'b0, acc_x} + (DATA_W+1)'(sub);
        low_sum    = {1'b0, opnd[HALF-1:0]} + {1'b0, acc_x[HALF-1:0]} + (HALF+1)'(sub);
        sum        = full_sum[DATA_W-1:0];
        carry      = full_sum[DATA_W];
        half_carry = low_sum[HALF];
    end

endmodule

// File: rtl/accalu_unit.sv
`timescale 1ns/1ps
// Module: accalu_unit
// Logic, move, complement, step and rotate-through-carry operations.
// Assumes c_in is the stored carry bit as it stands before this operation.
module accalu_unit
    import accalu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] opnd,
    input  logic [DATA_W-1:0] acc,
    input  logic              c_in,
    output logic [DATA_W-1:0] res,
    output logic              c_out
);

    // Compute the single-cycle result and the bit shifted out by a rotate.
    always_comb begin
        res   = opnd;
        c_out = c_in;
        case (op_code)
            OP_AND:  res = opnd & acc;
            OP_IOR:  res = opnd | acc;
            OP_XOR:  res = opnd ^ acc;
            OP_MOVF: res = opnd;
            OP_MOVW: res = acc;
            OP_COMF: res = ~opnd;
            OP_INCF: res = opnd + DATA_W'(1);
            OP_DECF: res = opnd - DATA_W'(1);
            OP_RLF: begin
                res   = {opnd[DATA_W-2:0], c_in};
                c_out = opnd[DATA_W-1];
            end
            OP_RRF: begin
                res   = {c_in, opnd[DATA_W-1:1]};
                c_out = opnd[0];
            end
            OP_CLR:  res = '0;
            default: res = opnd;
        endcase
    end

endmodule

// File: rtl/accalu_flagreg.sv
`timescale 1ns/1ps
// Module: accalu_flagreg
// Holds the status bits. Each bit loads only when its update-mask bit is set.
// Assumes a synchronous active-low reset that clears every bit.
module accalu_flagreg
    import accalu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   exec_en,
    input  flags_t upd_mask,
    input  flags_t next_flags,
    output flags_t flags_q
);

    logic [FLAG_CNT-1:0] mask_v, next_v, q_v;

    assign mask_v  = upd_mask;
    assign next_v  = next_flags;
    assign flags_q = q_v;

    for (genvar gi = 0; gi < FLAG_CNT; gi++) begin : g_bit
        // Load one status bit when the executed operation updates it.
        always_ff @(posedge clk) begin
            if (!rst_n)                       q_v[gi] <= 1'b0;
            else if (exec_en && mask_v[gi])   q_v[gi] <= next_v[gi];
        end
    end

endmodule

// File: rtl/accalu_core.sv
`timescale 1ns/1ps
// Module: accalu_core (top)
// Accumulator ALU: selects the operand (file register or literal), computes
// the result, routes it to W or f and updates the C, DC and Z status bits.
// Assumes the caller stores the result using w_we / f_we in the same cycle.
module accalu_core
    import accalu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_en,
    input  logic [3:0]        op_code,
    input  logic              lit_sel,
    input  logic              dest_f,
    input  logic [DATA_W-1:0] w_in,
    input  logic [DATA_W-1:0] f_in,
    input  logic [DATA_W-1:0] k_in,
    output logic [DATA_W-1:0] result,
    output logic              w_we,
    output logic              f_we,
    output logic              c_flag,
    output logic              dc_flag,
    output logic              z_flag
);

    logic [DATA_W-1:0] opnd;
    logic [DATA_W-1:0] arith_sum, unit_res;
    logic              arith_c, arith_dc, unit_c;
    logic              use_arith, arith_sub;
    flags_t            upd_mask, next_flags, flags_q;

    // Pick the second operand: literal or file register.
    always_comb opnd = lit_sel ? k_in : f_in;

    accalu_decode u_dec (
        .exec_en   (exec_en),
        .op_code   (op_code),
        .lit_sel   (lit_sel),
        .dest_f    (dest_f),
        .w_we      (w_we),
        .f_we      (f_we),
        .upd_mask  (upd_mask),
        .use_arith (use_arith),
        .arith_sub (arith_sub)
    );

    accalu_addsub #(.DATA_W(DATA_W)) u_arith (
        .opnd       (opnd),
        .acc        (w_in),
        .sub        (arith_sub),
        .sum        (arith_sum),
        .carry      (arith_c),
        .half_carry (arith_dc)
    );

    accalu_unit #(.DATA_W(DATA_W)) u_unit (
        .op_code (op_code),
        .opnd    (opnd),
        .acc     (w_in),
        .c_in    (flags_q.c),
        .res     (unit_res),
        .c_out   (unit_c)
    );

    // Merge the two result paths and form the candidate status bits.
    always_comb begin
        result        = use_arith ? arith_sum : unit_res;
        next_flags.c  = use_arith ? arith_c : unit_c;
        next_flags.dc = arith_dc;
        next_flags.z  = (result == '0);
    end

    accalu_flagreg u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .exec_en    (exec_en),
        .upd_mask   (upd_mask),
        .next_flags (next_flags),
        .flags_q    (flags_q)
    );

    // Present the stored status bits.
    always_comb begin
        c_flag  = flags_q.c;
        dc_flag = flags_q.dc;
        z_flag  = flags_q.z;
    end

endmodule

// File: rtl/accalu_chk.sv
`timescale 1ns/1ps
// Module: accalu_chk
// Property checker for accalu_core, attached through bind below.
module accalu_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              exec_en,
    input logic [3:0]        op_code,
    input logic              lit_sel,
    input logic              dest_f,
    input logic [DATA_W-1:0] w_in,
    input logic [DATA_W-1:0] f_in,
    input logic [DATA_W-1:0] k_in,
    input logic [DATA_W-1:0] result,
    input logic              w_we,
    input logic              f_we,
    input logic              c_flag,
    input logic              dc_flag,
    input logic              z_flag
);

    logic known;
    assign known = (op_code <= 4'd12);

    assert_reg_dest_R1: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && known && !lit_sel |-> (f_we == dest_f) && (w_we == !dest_f));

    assert_lit_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && known && lit_sel |-> w_we && !f_we);

    assert_add_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && op_code == 4'd0 && !lit_sel |=>
        c_flag == (({1'b0, $past(f_in)} + {1'b0, $past(w_in)}) > (DATA_W+1)'((1 << DATA_W) - 1)));

    assert_logic_keeps_c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && (op_code == 4'd2 || op_code == 4'd3 || op_code == 4'd4) |=>
        $stable(c_flag) && $stable(dc_flag));

    assert_movf_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && op_code == 4'd5 |=> z_flag == ($past(result) == '0));

    assert_movw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && op_code == 4'd6 |-> result == w_in);

    assert_step_keeps_c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && (op_code == 4'd8 || op_code == 4'd9) |=>
        $stable(c_flag) && $stable(dc_flag));

    assert_rlf_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && op_code == 4'd10 && !lit_sel |=> c_flag == $past(f_in[DATA_W-1]));

    assert_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en && op_code == 4'd12 |-> result == '0);

    assert_idle_we_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_en && known) |-> !w_we && !f_we);

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_en && known) |=> $stable(c_flag) && $stable(dc_flag) && $stable(z_flag));

    assert_reset_R13: assert property (@(posedge clk)
        !rst_n |=> !c_flag && !dc_flag && !z_flag);

endmodule

bind accalu_core accalu_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_code(op_code),
    .lit_sel(lit_sel), .dest_f(dest_f), .w_in(w_in), .f_in(f_in), .k_in(k_in),
    .result(result), .w_we(w_we), .f_we(f_we),
    .c_flag(c_flag), .dc_flag(dc_flag), .z_flag(z_flag)
);

// File: tb/accalu_core_tb_top.sv
`timescale 1ns/1ps
// Bench for accalu_core: a walked vector table, directed checks, then random
// operations compared with a reference model written from the requirements.
module accalu_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_en = 1'b0;
    logic [3:0] op_code = '0;
    logic       lit_sel = 1'b0;
    logic       dest_f = 1'b0;
    logic [7:0] w_in = '0, f_in = '0, k_in = '0;
    logic [7:0] result;
    logic       w_we, f_we, c_flag, dc_flag, z_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit m_c, m_dc, m_z;

    always #5 clk = ~clk;

    accalu_core dut_i (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_code(op_code),
        .lit_sel(lit_sel), .dest_f(dest_f), .w_in(w_in), .f_in(f_in), .k_in(k_in),
        .result(result), .w_we(w_we), .f_we(f_we),
        .c_flag(c_flag), .dc_flag(dc_flag), .z_flag(z_flag)
    );

    // Vector: {op, lit, d, w, f, k, result, C, DC, Z}; flags carry over in order.
    localparam int NV = 18;
    localparam logic [40:0] VEC [NV] = '{
        {4'd0,  1'b0, 1'b0, 8'h0F, 8'h01, 8'h00, 8'h10, 1'b0, 1'b1, 1'b0}, // R3 nibble carry
        {4'd0,  1'b0, 1'b1, 8'hF0, 8'h10, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1}, // R3 wrap, Z
        {4'd1,  1'b0, 1'b0, 8'h01, 8'h03, 8'h00, 8'h02, 1'b1, 1'b1, 1'b0}, // R4 no borrow
        {4'd1,  1'b0, 1'b1, 8'h05, 8'h03, 8'h00, 8'hFE, 1'b0, 1'b0, 1'b0}, // R4 borrow
        {4'd2,  1'b1, 1'b1, 8'h3C, 8'h00, 8'hC3, 8'h00, 1'b0, 1'b0, 1'b1}, // R5 R2 and-lit
        {4'd3,  1'b0, 1'b0, 8'h50, 8'h0A, 8'h00, 8'h5A, 1'b0, 1'b0, 1'b0}, // R5 or
        {4'd4,  1'b1, 1'b0, 8'hFF, 8'h00, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b1}, // R5 R2 xor-lit
        {4'd10, 1'b0, 1'b1, 8'h00, 8'h81, 8'h00, 8'h02, 1'b1, 1'b0, 1'b1}, // R10 rlf
        {4'd11, 1'b0, 1'b0, 8'h00, 8'h02, 8'h00, 8'h81, 1'b0, 1'b0, 1'b1}, // R10 rrf
        {4'd5,  1'b0, 1'b1, 8'h00, 8'h7E, 8'h00, 8'h7E, 1'b0, 1'b0, 1'b0}, // R6 movf d=1
        {4'd7,  1'b0, 1'b0, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1}, // R8 comf
        {4'd8,  1'b0, 1'b1, 8'h00, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1}, // R9 inc wrap
        {4'd9,  1'b0, 1'b0, 8'h00, 8'h01, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1}, // R9 dec to 0
        {4'd6,  1'b0, 1'b1, 8'hA5, 8'h00, 8'h00, 8'hA5, 1'b0, 1'b0, 1'b1}, // R7 movw to f
        {4'd12, 1'b0, 1'b0, 8'h33, 8'h44, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1}, // R11 clr
        {4'd0,  1'b1, 1'b1, 8'h08, 8'h00, 8'h08, 8'h10, 1'b0, 1'b1, 1'b0}, // R3 R2 add-lit
        {4'd8,  1'b0, 1'b0, 8'h00, 8'h0F, 8'h00, 8'h10, 1'b0, 1'b1, 1'b0}, // R9 DC kept
        {4'd1,  1'b1, 1'b0, 8'h10, 8'h00, 8'h10, 8'h00, 1'b1, 1'b1, 1'b1}  // R4 R2 sub-lit
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one operation after a falling edge, check combinational outputs,
    // let one rising edge consume it, then check the stored status bits.
    task automatic apply(input logic [3:0] op, input logic lit, input logic d,
                         input logic [7:0] w, input logic [7:0] f, input logic [7:0] k,
                         input logic en, input logic chk_res, input logic [7:0] exp_res,
                         input logic [2:0] exp_flags, input string req);
        logic known;
        known = (op <= 4'd12);
        @(negedge clk);
        op_code = op; lit_sel = lit; dest_f = d; w_in = w; f_in = f; k_in = k; exec_en = en;
        #1;
        if (chk_res) check({req, " result"}, 32'(result), 32'(exp_res));
        check({req, " w_we"}, 32'(w_we), 32'(en && known && (lit || !d)));
        check({req, " f_we"}, 32'(f_we), 32'(en && known && !lit && d));
        @(posedge clk);
        #1 exec_en = 1'b0;
        check({req, " flags"}, 32'({c_flag, dc_flag, z_flag}), 32'(exp_flags));
    endtask

    // Reference model from the requirement text.
    task automatic model(input logic [3:0] op, input logic lit, input logic [7:0] w,
                         input logic [7:0] f, input logic [7:0] k, output logic [7:0] r);
        logic [7:0] s;
        logic [8:0] t;
        logic [4:0] h;
        s = lit ? k : f;
        r = s;
        case (op)
            4'd0: begin t = s + w; h = s[3:0] + w[3:0]; r = t[7:0];
                        m_c = t[8]; m_dc = h[4]; m_z = (r == 0); end
            4'd1: begin r = s - w; m_c = (s >= w); m_dc = (s[3:0] >= w[3:0]); m_z = (r == 0); end
            4'd2: begin r = s & w; m_z = (r == 0); end
            4'd3: begin r = s | w; m_z = (r == 0); end
            4'd4: begin r = s ^ w; m_z = (r == 0); end
            4'd5: begin r = s; m_z = (r == 0); end
            4'd6: r = w;
            4'd7: begin r = ~s; m_z = (r == 0); end
            4'd8: begin r = s + 8'd1; m_z = (r == 0); end
            4'd9: begin r = s - 8'd1; m_z = (r == 0); end
            4'd10: begin r = {s[6:0], m_c}; m_c = s[7]; end
            4'd11: begin r = {m_c, s[7:1]}; m_c = s[0]; end
            4'd12: begin r = 8'h00; m_z = 1'b1; end
            default: r = s;
        endcase
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(posedge clk);
        #1;
        check("R13 reset flags", 32'({c_flag, dc_flag, z_flag}), 32'd0);
        check("R12 idle w_we", 32'(w_we), 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][40:37], VEC[i][36], VEC[i][35], VEC[i][34:27], VEC[i][26:19],
                  VEC[i][18:11], 1'b1, 1'b1, VEC[i][10:3], VEC[i][2:0], $sformatf("vec%0d", i));
        end

        // R12: not enabled, and a reserved code: no writes, flags held at 3'b111.
        apply(4'd0, 1'b0, 1'b0, 8'hFF, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 3'b111, "R12 idle");
        apply(4'd13, 1'b0, 1'b1, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 3'b111, "R12 reserved");
        apply(4'd15, 1'b1, 1'b0, 8'h01, 8'h00, 8'h01, 1'b1, 1'b0, 8'h00, 3'b111, "R12 reserved lit");
        // R1: move f to W with d=0, Z from a nonzero value.
        apply(4'd5, 1'b0, 1'b0, 8'h00, 8'h80, 8'h00, 1'b1, 1'b1, 8'h80, 3'b110, "R1 R6 movf to W");
        // R11: clear leaves C and DC at 1.
        apply(4'd12, 1'b0, 1'b1, 8'h00, 8'h9C, 8'h00, 1'b1, 1'b1, 8'h00, 3'b111, "R11 clr keeps C");

        // R13: reset in mid-run clears flags.
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #1 check("R13 mid-run reset", 32'({c_flag, dc_flag, z_flag}), 32'd0);
        @(negedge clk) rst_n = 1'b1;
        m_c = 0; m_dc = 0; m_z = 0;

        // Random phase against the model; covers R1..R12.
        for (int i = 0; i < 400; i++) begin
            logic [3:0] op;
            logic lit, d, en;
            logic [7:0] w, f, k;
            op  = 4'($urandom_range(0, 15));
            lit = 1'($urandom_range(0, 1));
            d   = 1'($urandom_range(0, 1));
            en  = ($urandom_range(0, 9) != 0);
            w   = 8'($urandom); f = 8'($urandom); k = 8'($urandom);
            if (i % 7 == 0) f = w;
            if (en) model(op, lit, w, f, k, r);
            else r = 8'h00;
            apply(op, lit, d, w, f, k, en, en && (op <= 4'd12), r,
                  {m_c, m_dc, m_z}, $sformatf("rnd%0d op%0d", i, op));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule